// File: doc/BRIEF.md
# Strap Sampler and Test Access Port Selector

This block reads a small set of hardware strap pins and decides, from the device life-cycle phase, which debug or test access port gets the chip's JTAG pins. There are three design-for-test (DFT) strap bits and two TAP-choice strap bits. The life-cycle phase decides whether each strap is captured once, when the power controller signals that boot sampling may happen, or followed on every clock, or never read at all. The captured TAP-choice bits are then decoded into one of three access ports, or into no port. The phase also limits which ports may be reached.

A small controller has two states. `SMP_AWAIT_BOOT` is the reset state: nothing is sampled. The transition `BOOT_CAPTURE` happens on the first boot strobe. It takes the one-time snapshot and moves to `SMP_RUNNING`. In `SMP_RUNNING`, the transition `STAY_RUNNING` repeats every cycle until the next reset. In that state, further strobes are ignored, and the TAP-choice straps are followed continuously when the phase allows it. A test controller can assert a hold input to freeze that continuous following, for example during boundary scan.

While any port is selected, the attribute bus for the JTAG pads is driven to all zeros. The stored attribute values arriving at the block's input are not changed. This keeps inversion or pull settings from disturbing the JTAG signals.

Top module: `strap_tap_sel`

## Requirements
- R1: After reset, `dft_strap_o` is 0, `tap_sel_o` is 0 (no port), `jtag_active_o` is 0 and `jtag_attr_o` equals `jtag_attr_i`. No strap is sampled until the first boot strobe.
- R2: Life-cycle phase encoding on `lc_state_i`: 0 test-unlocked, 1 RMA, 2 DEV, 3 other. On the first boot strobe, `dft_strap_o` takes the DFT pins if the phase is 0 or 1. Otherwise it becomes 0. It never changes again until reset.
- R3: TAP strap bit 0 is captured at the first boot strobe in every phase. After that strobe, in phases 0 and 1, it follows its pin on every clock edge.
- R4: TAP strap bit 1 is captured at the first boot strobe in phases 0, 1 and 2, and is forced to 0 in phase 3. After that strobe, in phases 0 and 1, it follows its pin on every clock edge.
- R5: Only the first boot strobe after reset captures. Later strobes have no effect on any output.
- R6: The captured pair {bit1,bit0} decodes into `tap_sel_o` (0 none, 1 life-cycle port, 2 CPU debug port, 3 DFT port) as follows. 00 gives 0 and 01 gives 1 in every phase. 10 gives 2 only in phases 0–2. 11 gives 3 only in phases 0–1. Any other combination gives 0. `jtag_active_o` is 1 exactly when `tap_sel_o` is not 0.
- R7: While `hold_i` is 1, continuous following of the TAP straps pauses and the last captured values are kept. The boot-strobe capture itself is not blocked by `hold_i`.
- R8: While a port is selected, `jtag_attr_o` is all zeros. Otherwise it equals `jtag_attr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lc_state_i | input | 2 | Life-cycle phase (0 test-unlocked, 1 RMA, 2 DEV, 3 other) |
| boot_strobe_i | input | 1 | Boot sampling strobe from the power controller |
| hold_i | input | 1 | Freezes continuous TAP strap following |
| dft_pins_i | input | 3 | DFT strap pins |
| tap_pins_i | input | 2 | TAP-choice strap pins, bit 1 and bit 0 |
| jtag_attr_i | input | NUM_PADS*ATTR_W | Stored pad attributes of the JTAG pads |
| dft_strap_o | output | 3 | Captured DFT strap bits |
| tap_sel_o | output | 2 | Selected access port |
| jtag_active_o | output | 1 | A port is selected |
| jtag_attr_o | output | NUM_PADS*ATTR_W | Gated pad attributes of the JTAG pads |

## Verification
The bench targets the following corner cases, each with the fault it would expose:
- A second boot strobe carrying different pin values. A design that re-arms its capture would overwrite the DFT bits.
- A DEV-phase capture of encoding 11. A design that skips the phase check would open the DFT port.
- A capture in the "other" phase. A design that samples bit 1 there would turn 11 into a DFT request instead of reducing it to the life-cycle port.
- Pin changes after a DEV boot. A design that samples continuously in every phase would follow those changes.
- A strobe while hold is high, and pin changes while hold is high. A design that wires hold wrongly would either lose the boot capture or keep following the pins.
- Attribute pass-through in both the selected and unselected cases.

// File: rtl/strap_tap_pkg.sv
package strap_tap_pkg;

    localparam int unsigned DFT_BITS = 3;
    localparam int unsigned TAP_BITS = 2;

    typedef enum logic [1:0] {
        LC_TEST_UNLK = 2'd0,
        LC_RMA       = 2'd1,
        LC_DEV       = 2'd2,
        LC_OTHER     = 2'd3
    } lc_phase_e;

    typedef enum logic [1:0] {
        TAP_NONE      = 2'd0,
        TAP_LIFECYCLE = 2'd1,
        TAP_CPU_DBG   = 2'd2,
        TAP_DFT       = 2'd3
    } tap_pick_e;

    typedef enum logic {
        SMP_AWAIT_BOOT = 1'b0,
        SMP_RUNNING    = 1'b1
    } smp_state_e;

    // Phases in which test access is fully open.
    function automatic logic lc_is_open(lc_phase_e ph);
        return (ph == LC_TEST_UNLK) || (ph == LC_RMA);
    endfunction

    // Whether TAP strap bit 'idx' may be captured at boot in phase 'ph'.
    function automatic logic tap_boot_allowed(int unsigned idx, lc_phase_e ph);
        if (idx == 0) begin
            return 1'b1;
        end
        return ph != LC_OTHER;
    endfunction

endpackage

// File: rtl/strap_seq_fsm.sv
module strap_seq_fsm
    import strap_tap_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       boot_strobe_i,
    output smp_state_e state_o,
    output logic       boot_cap_o,
    output logic       run_o
);

    smp_state_e state_q;
    smp_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SMP_AWAIT_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMP_AWAIT_BOOT: begin
                if (boot_strobe_i) begin
                    state_d = SMP_RUNNING;   // BOOT_CAPTURE
                end
            end
            SMP_RUNNING: begin
                state_d = SMP_RUNNING;       // STAY_RUNNING
            end
            default: begin
                state_d = SMP_AWAIT_BOOT;
            end
        endcase
    end

    always_comb begin
        boot_cap_o = 1'b0;
        run_o      = 1'b0;
        unique case (state_q)
            SMP_AWAIT_BOOT: begin
                boot_cap_o = boot_strobe_i;
            end
            SMP_RUNNING: begin
                run_o = 1'b1;
            end
            default: begin
                boot_cap_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_tap_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  lc_phase_e           lc_i,
    input  logic                boot_cap_i,
    input  logic                run_i,
    input  logic                hold_i,
    input  logic [DFT_BITS-1:0] dft_pins_i,
    input  logic [TAP_BITS-1:0] tap_pins_i,
    output logic [DFT_BITS-1:0] dft_q_o,
    output logic [TAP_BITS-1:0] tap_q_o
);

    logic open_phase;
    logic follow_en;

    assign open_phase = lc_is_open(lc_i);
    assign follow_en  = run_i && open_phase && !hold_i;

    // DFT straps: single snapshot at boot, only in open phases.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dft_q_o <= '0;
        end else if (boot_cap_i) begin
            dft_q_o <= open_phase ? dft_pins_i : '0;
        end
    end

    // TAP straps: per-bit boot policy plus continuous following.
    for (genvar b = 0; b < TAP_BITS; b++) begin : g_tap_bit
        logic boot_ok;
        assign boot_ok = tap_boot_allowed(b, lc_i);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                tap_q_o[b] <= 1'b0;
            end else if (boot_cap_i) begin
                tap_q_o[b] <= boot_ok ? tap_pins_i[b] : 1'b0;
            end else if (follow_en) begin
                tap_q_o[b] <= tap_pins_i[b];
            end
        end
    end

endmodule

// File: rtl/tap_route.sv
module tap_route
    import strap_tap_pkg::*;
#(
    parameter int unsigned NUM_PADS = 4,
    parameter int unsigned ATTR_W   = 13,
    localparam int unsigned BUS_W   = NUM_PADS * ATTR_W
) (
    input  lc_phase_e           lc_i,
    input  logic [TAP_BITS-1:0] tap_q_i,
    input  logic [BUS_W-1:0]    attr_i,
    output tap_pick_e           sel_o,
    output logic                active_o,
    output logic [BUS_W-1:0]    attr_o
);

    always_comb begin
        sel_o = TAP_NONE;
        unique case (tap_q_i)
            2'b00: sel_o = TAP_NONE;
            2'b01: sel_o = TAP_LIFECYCLE;
            2'b10: sel_o = (lc_i != LC_OTHER) ? TAP_CPU_DBG : TAP_NONE;
            2'b11: sel_o = lc_is_open(lc_i) ? TAP_DFT : TAP_NONE;
            default: sel_o = TAP_NONE;
        endcase
    end

    assign active_o = (sel_o != TAP_NONE);

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        assign attr_o[p*ATTR_W +: ATTR_W] =
            active_o ? '0 : attr_i[p*ATTR_W +: ATTR_W];
    end

endmodule

// File: rtl/strap_tap_sel.sv
module strap_tap_sel
    import strap_tap_pkg::*;
#(
    parameter int unsigned NUM_PADS = 4,
    parameter int unsigned ATTR_W   = 13,
    localparam int unsigned BUS_W   = NUM_PADS * ATTR_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [1:0]          lc_state_i,
    input  logic                boot_strobe_i,
    input  logic                hold_i,
    input  logic [DFT_BITS-1:0] dft_pins_i,
    input  logic [TAP_BITS-1:0] tap_pins_i,
    input  logic [BUS_W-1:0]    jtag_attr_i,
    output logic [DFT_BITS-1:0] dft_strap_o,
    output logic [1:0]          tap_sel_o,
    output logic                jtag_active_o,
    output logic [BUS_W-1:0]    jtag_attr_o
);

    lc_phase_e           lc_ph;
    smp_state_e          seq_state;
    logic                boot_cap;
    logic                run_en;
    logic [TAP_BITS-1:0] tap_bits_q;
    tap_pick_e           sel_pick;

    assign lc_ph = lc_phase_e'(lc_state_i);

    strap_seq_fsm u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .boot_strobe_i (boot_strobe_i),
        .state_o       (seq_state),
        .boot_cap_o    (boot_cap),
        .run_o         (run_en)
    );

    strap_capture u_cap (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lc_i       (lc_ph),
        .boot_cap_i (boot_cap),
        .run_i      (run_en),
        .hold_i     (hold_i),
        .dft_pins_i (dft_pins_i),
        .tap_pins_i (tap_pins_i),
        .dft_q_o    (dft_strap_o),
        .tap_q_o    (tap_bits_q)
    );

    tap_route #(
        .NUM_PADS (NUM_PADS),
        .ATTR_W   (ATTR_W)
    ) u_route (
        .lc_i     (lc_ph),
        .tap_q_i  (tap_bits_q),
        .attr_i   (jtag_attr_i),
        .sel_o    (sel_pick),
        .active_o (jtag_active_o),
        .attr_o   (jtag_attr_o)
    );

    assign tap_sel_o = sel_pick;

endmodule

// File: rtl/strap_tap_sel_chk.sv
module strap_tap_sel_chk #(
    parameter int unsigned BUS_W = 52
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       lc_state_i,
    input logic             boot_strobe_i,
    input logic             hold_i,
    input logic [2:0]       dft_strap_o,
    input logic [1:0]       tap_sel_o,
    input logic [BUS_W-1:0] jtag_attr_o,
    input logic             seq_state,
    input logic [1:0]       tap_bits_q
);

    AST_WAIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_state == 1'b0) |-> (dft_strap_o == 3'd0 && tap_bits_q == 2'd0)); // R1

    AST_DFT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_state == 1'b1) |=> $stable(dft_strap_o)); // R2

    AST_OTHER_NO_BIT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_state == 1'b0 && boot_strobe_i && lc_state_i == 2'd3) |=> (tap_bits_q[1] == 1'b0)); // R4

    AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_state == 1'b1) |=> (seq_state == 1'b1)); // R5

    AST_DFT_PORT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tap_sel_o == 2'd3) |-> (lc_state_i <= 2'd1)); // R6

    AST_CPU_PORT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tap_sel_o == 2'd2) |-> (lc_state_i != 2'd3)); // R6

    AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_state == 1'b1 && hold_i) |=> $stable(tap_bits_q)); // R7

    AST_ATTR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tap_sel_o != 2'd0) |-> (jtag_attr_o == '0)); // R8

endmodule

bind strap_tap_sel strap_tap_sel_chk #(.BUS_W(BUS_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lc_state_i    (lc_state_i),
    .boot_strobe_i (boot_strobe_i),
    .hold_i        (hold_i),
    .dft_strap_o   (dft_strap_o),
    .tap_sel_o     (tap_sel_o),
    .jtag_attr_o   (jtag_attr_o),
    .seq_state     (seq_state),
    .tap_bits_q    (tap_bits_q)
);

// File: tb/strap_tap_sel_tb_top.sv
module strap_tap_sel_tb_top;

    localparam int NP = 4;
    localparam int AW = 13;
    localparam int AB = NP * AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    lc = 2'd0;
    logic          strobe = 1'b0;
    logic          hold = 1'b0;
    logic [2:0]    dft_pins = 3'd0;
    logic [1:0]    tap_pins = 2'd0;
    logic [AB-1:0] attr_in = {NP{13'h1A5B}};
    logic [2:0]    dft_out;
    logic [1:0]    sel_out;
    logic          act_out;
    logic [AB-1:0] attr_out;

    always #4 clk = ~clk;   // 125 MHz

    strap_tap_sel #(.NUM_PADS(NP), .ATTR_W(AW)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .lc_state_i    (lc),
        .boot_strobe_i (strobe),
        .hold_i        (hold),
        .dft_pins_i    (dft_pins),
        .tap_pins_i    (tap_pins),
        .jtag_attr_i   (attr_in),
        .dft_strap_o   (dft_out),
        .tap_sel_o     (sel_out),
        .jtag_active_o (act_out),
        .jtag_attr_o   (attr_out)
    );

    typedef struct {
        logic [2:0]    dft;
        logic [1:0]    sel;
        logic          act;
        logic [AB-1:0] attr;
        string         tag;
    } exp_t;

    exp_t sb[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    logic       m_boot;
    logic [2:0] m_dft;
    logic [1:0] m_tap;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        strobe = 1'b0;
        hold   = 1'b0;
        repeat (3) @(negedge clk);
        m_boot = 1'b0;
        m_dft  = '0;
        m_tap  = '0;
        rst_n  = 1'b1;
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic [1:0] lc_v, input logic stb, input logic hld,
                        input logic [2:0] d, input logic [1:0] t, input string tag);
        exp_t e;
        logic open;
        @(negedge clk);
        lc = lc_v; strobe = stb; hold = hld; dft_pins = d; tap_pins = t;
        open = (lc_v <= 2'd1);
        if (!m_boot && stb) begin
            m_boot   = 1'b1;
            m_dft    = open ? d : 3'd0;
            m_tap[0] = t[0];
            m_tap[1] = (lc_v != 2'd3) ? t[1] : 1'b0;
        end else if (m_boot && open && !hld) begin
            m_tap = t;
        end
        case (m_tap)
            2'b00: e.sel = 2'd0;
            2'b01: e.sel = 2'd1;
            2'b10: e.sel = (lc_v != 2'd3) ? 2'd2 : 2'd0;
            default: e.sel = open ? 2'd3 : 2'd0;
        endcase
        e.dft  = m_dft;
        e.act  = (e.sel != 2'd0);
        e.attr = e.act ? '0 : attr_in;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare after each rising edge, away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "dft", 64'(dft_out), 64'(e.dft));
                check(e.tag, "sel", 64'(sel_out), 64'(e.sel));
                check(e.tag, "act", 64'(act_out), 64'(e.act));
                check(e.tag, "attr", 64'(attr_out), 64'(e.attr));
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state, R5 no sampling before the strobe
        step(2'd0, 0, 0, 3'b111, 2'b11, "R1_reset");
        step(2'd0, 0, 0, 3'b111, 2'b01, "R5_prestrobe");
        // R2 boot capture in test-unlocked
        step(2'd0, 1, 0, 3'b101, 2'b01, "R2_boot_tu");
        // R3 R4 continuous following, R6 DFT port, R8 gating
        step(2'd0, 0, 0, 3'b010, 2'b11, "R3_R4_follow");
        step(2'd0, 0, 0, 3'b010, 2'b11, "R8_gate");
        // R5 second strobe ignored
        step(2'd0, 1, 0, 3'b010, 2'b11, "R5_second_strobe");
        // R7 hold freezes
        step(2'd0, 0, 1, 3'b000, 2'b10, "R7_hold");
        step(2'd0, 0, 1, 3'b000, 2'b00, "R7_hold2");
        step(2'd0, 0, 0, 3'b000, 2'b10, "R7_release");
        // R6 phase change removes CPU port
        step(2'd3, 0, 0, 3'b000, 2'b10, "R6_other_cpu");
        step(2'd3, 0, 0, 3'b000, 2'b00, "R8_pass");

        do_reset();
        // R2 no DFT in DEV, R6 DFT port refused in DEV
        step(2'd2, 1, 0, 3'b111, 2'b11, "R2_R6_dev");
        // R3 R4 once only in DEV
        step(2'd2, 0, 0, 3'b111, 2'b01, "R3_R4_dev_once");
        step(2'd2, 0, 0, 3'b111, 2'b10, "R3_dev_once2");

        do_reset();
        step(2'd2, 1, 0, 3'b000, 2'b10, "R6_R4_dev_cpu");

        do_reset();
        // R4 bit 1 never sampled in other phase
        step(2'd3, 1, 0, 3'b110, 2'b11, "R4_other");
        step(2'd3, 0, 0, 3'b110, 2'b00, "R3_other_once");

        do_reset();
        step(2'd3, 1, 0, 3'b000, 2'b10, "R4_other_10");

        do_reset();
        // R7 hold does not block boot capture (RMA phase)
        step(2'd1, 1, 1, 3'b011, 2'b01, "R7_boot_hold");
        step(2'd1, 0, 1, 3'b011, 2'b11, "R7_boot_hold2");
        step(2'd1, 0, 0, 3'b011, 2'b11, "R3_rma_follow");

        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule